// File: doc/BRIEF.md
# Extended-Range Gamma Lookup with Interpolation

This block is the post-matrix gamma stage of a display colour pipeline. Each of its colour channels takes a signed fixed-point sample that can lie anywhere from -3.0 to +3.0. The stage drops the sign, so a negative sample is treated as its mirror image. It then turns the magnitude into a 12-bit output by linear interpolation in a per-channel table.

Magnitudes from 0.0 up to 1.0 fall on 512 evenly spaced intervals. These are bounded by entries 0 through 512, and entry 512 is the value for exactly 1.0. Magnitudes from 1.0 up to 3.0 are interpolated between entry 512 and one extra entry, 513, which holds the value for 3.0. Loading entry 513 with the same value as entry 512 turns the whole overshoot range into saturation at the 1.0 output.

The tables are filled through a plain write strobe with channel, address and data. All channels run side by side with a fixed two-clock latency, and a valid flag travels with the data.

Top module: `xrange_gamma_lut`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and after it is released, `out_valid` is 0 and `out_pix` is all zeros until the first pixel arrives.
- R2: Each channel's input is 13-bit two's complement with 10 fractional bits, so 1.0 is 1024. The magnitude |x| is what gets looked up, so x and -x give the same output. The value -4096 is taken as magnitude 4096.
- R3: For a magnitude m below 1024, let i = m >> 1 and b = m & 1. The output is T[i] + floor((T[i+1] - T[i]) * b / 2), where T is that channel's table.
- R4: For 1024 <= m < 3072, let t = m - 1024. The output is T[512] + floor((T[513] - T[512]) * t / 2048). At m = 1024 this gives exactly T[512].
- R5: Any magnitude of 3072 or more gives exactly T[513].
- R6: When T[513] equals T[512], every magnitude of 1024 or more gives T[512].
- R7: A pixel presented with `in_valid` high on clock edge k appears on `out_pix` with `out_valid` high after edge k+2. A cycle with `in_valid` low gives `out_valid` low two edges later. Back-to-back pixels stream out one per clock.
- R8: A write with `wr_en` high stores `wr_data` into entry `wr_addr` (0 to 513) of channel `wr_chan`, where channel c occupies bits [13c+12:13c] of `in_pix` and [12c+11:12c] of `out_pix`. A pixel sampled on the same edge as the write still sees the old entry, and a pixel sampled on any later edge sees the new one.
- R9: A write whose address is above 513, or whose channel number is 3 or more, changes no table entry.
- R10: Each channel has its own table, so a write to one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 39 | Three signed samples, 13 bits each, channel 0 in the low bits |
| wr_en | input | 1 | Table write strobe |
| wr_chan | input | 2 | Channel selected for the write |
| wr_addr | input | 10 | Table entry to write |
| wr_data | input | 12 | Value to store |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 36 | Three 12-bit results, channel 0 in the low bits |

## Verification
The vector sweep tries magnitudes at both ends of the base range (0, 1, odd and even codes, 1023), at the seam at 1024, inside the overshoot span, at the clamp point 3072, and beyond it up to the most negative code. This separates the base interpolation, the overshoot interpolation and the clamp from one another.

Channel 1 always gets the negated sample, which shows mirroring, not clamping at zero. One table rises, one falls and one wraps around, so the interpolation steps are both positive and negative, and a wrong floor or rounding shows up on odd codes.

Directed cases cover four further behaviours:
- a write that arrives together with a pixel, to show where the write takes effect;
- writes that should be dropped because of their address or channel;
- equal overshoot entries, which should saturate;
- a streaming burst, which shows the latency and that valid travels with the data.

// File: rtl/xrg_pkg.sv
package xrg_pkg;
   // Which part of the magnitude axis a sample falls on
   typedef enum logic [1:0] {
      SEG_BASE = 2'd0,
      SEG_EXT  = 2'd1,
      SEG_TOP  = 2'd2
   } xrg_seg_e;

   // Entries beyond the evenly spaced base nodes: the 1.0 node and the 3.0 node
   localparam int unsigned XRG_EXTRA_NODES = 2;
endpackage

// File: rtl/xrg_split.sv
module xrg_split
   import xrg_pkg::*;
#(
   parameter int unsigned IW      = 13,
   parameter int unsigned IN_FRAC = 10,
   parameter int unsigned AW_LO   = 9,
   parameter int unsigned TAW     = 10,
   parameter int unsigned FW      = 11
) (
   input  logic [IW-1:0]  x,
   output logic [TAW-1:0] lo_addr,
   output logic [TAW-1:0] hi_addr,
   output logic [FW-1:0]  frac
);
   localparam int unsigned FB     = IN_FRAC - AW_LO;
   localparam int unsigned N_BASE = 1 << AW_LO;
   localparam logic [IW-1:0] ONE_V = IW'(1) << IN_FRAC;
   localparam logic [IW-1:0] TOP_V = IW'(3) << IN_FRAC;
   localparam logic [TAW-1:0] NODE_ONE   = TAW'(N_BASE);
   localparam logic [TAW-1:0] NODE_THREE = TAW'(N_BASE + 1);

   logic [IW-1:0]  mag;
   logic [IW-1:0]  over;
   logic [TAW-1:0] base_idx;
   logic [FW-1:0]  base_frac;
   xrg_seg_e       seg;

   always_comb begin
      mag  = x[IW-1] ? (~x + IW'(1)) : x;
      over = mag - ONE_V;
      if (mag >= TOP_V)      seg = SEG_TOP;
      else if (mag >= ONE_V) seg = SEG_EXT;
      else                   seg = SEG_BASE;
      base_idx = TAW'(mag >> FB);
   end

   // Base-range fraction is left-aligned to the shared FW-bit fraction
   if (FB == 0) begin : g_no_base_frac
      assign base_frac = '0;
   end else begin : g_base_frac
      assign base_frac = {mag[FB-1:0], {(FW-FB){1'b0}}};
   end

   always_comb begin
      unique case (seg)
         SEG_BASE: begin
            lo_addr = base_idx;
            hi_addr = base_idx + TAW'(1);
            frac    = base_frac;
         end
         SEG_EXT: begin
            lo_addr = NODE_ONE;
            hi_addr = NODE_THREE;
            frac    = FW'(over);
         end
         default: begin
            lo_addr = NODE_THREE;
            hi_addr = NODE_THREE;
            frac    = '0;
         end
      endcase
   end
endmodule

// File: rtl/xrg_table.sv
module xrg_table #(
   parameter int unsigned DW    = 12,
   parameter int unsigned DEPTH = 514,
   parameter int unsigned TAW   = 10
) (
   input  logic           clk,
   input  logic           we,
   input  logic [TAW-1:0] wa,
   input  logic [DW-1:0]  wd,
   input  logic           rst_n,
   input  logic [TAW-1:0] ra_lo,
   input  logic [TAW-1:0] ra_hi,
   output logic [DW-1:0]  rd_lo,
   output logic [DW-1:0]  rd_hi
);
   localparam logic [TAW-1:0] LAST = TAW'(DEPTH - 1);

   logic [DW-1:0] mem [DEPTH];
   logic          hit;

   assign hit = we && (wa <= LAST);

   always_ff @(posedge clk) begin
      if (hit) mem[wa] <= wd;
   end

   assign rd_lo = mem[ra_lo];
   assign rd_hi = mem[ra_hi];

   // A legal write is readable from the next cycle on
   assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (mem[$past(wa)] == $past(wd)));
endmodule

// File: rtl/xrg_interp.sv
module xrg_interp #(
   parameter int unsigned DW = 12,
   parameter int unsigned FW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   input  logic [FW-1:0] frac,
   output logic [DW-1:0] out_q
);
   localparam int unsigned PW = DW + FW + 2;

   logic [PW-1:0]        dx;
   logic [PW-1:0]        fx;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] step;
   logic signed [PW-1:0] res;

   always_comb begin
      dx   = PW'($signed({1'b0, hi}) - $signed({1'b0, lo}));
      fx   = PW'(frac);
      prod = $signed(dx * fx);
      step = prod >>> FW;
      res  = step + $signed(PW'(lo));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   out_q <= '0;
      else if (vld) out_q <= DW'(res);
   end

   // The result never leaves the span of its two nodes
   assert_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> (($past(lo) <= $past(hi)) ?
               (out_q >= $past(lo) && out_q <= $past(hi)) :
               (out_q <= $past(lo) && out_q >= $past(hi))));

   // A zero fraction lands exactly on the lower node
   assert_node_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && frac == '0) |=> (out_q == $past(lo)));
endmodule

// File: rtl/xrange_gamma_lut.sv
module xrange_gamma_lut
   import xrg_pkg::*;
#(
   parameter int unsigned NCH     = 3,
   parameter int unsigned DW      = 12,
   parameter int unsigned IN_INT  = 2,
   parameter int unsigned IN_FRAC = 10,
   parameter int unsigned AW_LO   = 9,
   localparam int unsigned IW     = 1 + IN_INT + IN_FRAC,
   localparam int unsigned DEPTH  = (1 << AW_LO) + XRG_EXTRA_NODES,
   localparam int unsigned TAW    = $clog2(DEPTH),
   localparam int unsigned CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [NCH*IW-1:0] in_pix,
   input  logic              wr_en,
   input  logic [CHW-1:0]    wr_chan,
   input  logic [TAW-1:0]    wr_addr,
   input  logic [DW-1:0]     wr_data,
   output logic              out_valid,
   output logic [NCH*DW-1:0] out_pix
);
   // Fraction width of the 1.0..3.0 span (two units wide)
   localparam int unsigned FW = IN_FRAC + 1;

   if (IN_INT < 2) begin : g_chk_int
      $error("IN_INT must be at least 2 so that 3.0 is representable");
   end
   if (IN_FRAC < AW_LO) begin : g_chk_frac
      $error("IN_FRAC must be no smaller than AW_LO");
   end
   if (NCH < 1) begin : g_chk_nch
      $error("NCH must be at least 1");
   end
   if (DW < 2) begin : g_chk_dw
      $error("DW must be at least 2");
   end

   logic s1_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         s1_vld    <= in_valid;
         out_valid <= s1_vld;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic           we;
      logic [TAW-1:0] lo_a;
      logic [TAW-1:0] hi_a;
      logic [FW-1:0]  frac_c;
      logic [DW-1:0]  lo_v;
      logic [DW-1:0]  hi_v;
      logic [DW-1:0]  s1_lo;
      logic [DW-1:0]  s1_hi;
      logic [FW-1:0]  s1_frac;

      assign we = wr_en && (wr_chan == CHW'(c));

      xrg_split #(
         .IW(IW), .IN_FRAC(IN_FRAC), .AW_LO(AW_LO), .TAW(TAW), .FW(FW)
      ) u_split (
         .x       (in_pix[c*IW +: IW]),
         .lo_addr (lo_a),
         .hi_addr (hi_a),
         .frac    (frac_c)
      );

      xrg_table #(
         .DW(DW), .DEPTH(DEPTH), .TAW(TAW)
      ) u_table (
         .clk   (clk),
         .we    (we),
         .wa    (wr_addr),
         .wd    (wr_data),
         .rst_n (rst_n),
         .ra_lo (lo_a),
         .ra_hi (hi_a),
         .rd_lo (lo_v),
         .rd_hi (hi_v)
      );

      // Stage 1: node values and fraction captured together
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s1_lo   <= '0;
            s1_hi   <= '0;
            s1_frac <= '0;
         end else if (in_valid) begin
            s1_lo   <= lo_v;
            s1_hi   <= hi_v;
            s1_frac <= frac_c;
         end
      end

      // Stage 2: interpolation into the output register
      xrg_interp #(
         .DW(DW), .FW(FW)
      ) u_interp (
         .clk   (clk),
         .rst_n (rst_n),
         .vld   (s1_vld),
         .lo    (s1_lo),
         .hi    (s1_hi),
         .frac  (s1_frac),
         .out_q (out_pix[c*DW +: DW])
      );
   end

   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

// File: tb/xrange_gamma_lut_tb.sv
module xrange_gamma_lut_tb;
   localparam int NCH = 3;
   localparam int IW  = 13;
   localparam int DW  = 12;
   localparam int DEP = 514;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [NCH*IW-1:0] in_pix = '0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_chan = '0;
   logic [9:0]        wr_addr = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              out_valid;
   logic [NCH*DW-1:0] out_pix;

   int n_chk = 0;
   int n_bad = 0;
   int shadow [NCH][DEP];

   always #2 clk = ~clk;

   xrange_gamma_lut u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
      .wr_en(wr_en), .wr_chan(wr_chan), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_valid(out_valid), .out_pix(out_pix)
   );

   localparam int NV = 23;
   localparam int VEC [NV] = '{0, 1, 2, 3, 511, 1022, 1023, 1024, 1025, 1500,
                               2047, 2048, 3071, 3072, 3073, 4095, -1, -3,
                               -1024, -2049, -3072, -4096, 777};

   function automatic int init_val(int c, int i);
      if (i == 513) return (c == 0) ? 4000 : (c == 1) ? 100 : 1234;
      if (c == 0) return i * 5;
      if (c == 1) return 4095 - i * 7;
      return (i * 13) % 4096;
   endfunction

   function automatic int model(int c, int x);
      int m, i, b, t, lo, hi;
      m = (x < 0) ? -x : x;
      if (m >= 3072) return shadow[c][513];
      if (m >= 1024) begin
         t  = m - 1024;
         lo = shadow[c][512];
         hi = shadow[c][513];
         return lo + (((hi - lo) * t) >>> 11);
      end
      i  = m >> 1;
      b  = m & 1;
      lo = shadow[c][i];
      hi = shadow[c][i + 1];
      return lo + (((hi - lo) * b) >>> 1);
   endfunction

   function automatic int chan_out(int c);
      return int'(out_pix[c*DW +: DW]);
   endfunction

   task automatic check(string req, int got, int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic set_pix(int x0, int x1, int x2);
      in_pix[0*IW +: IW] = IW'(x0);
      in_pix[1*IW +: IW] = IW'(x1);
      in_pix[2*IW +: IW] = IW'(x2);
   endtask

   task automatic do_write(int c, int a, int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_chan = 2'(c);
      wr_addr = 10'(a);
      wr_data = 12'(d);
      @(negedge clk);
      wr_en = 1'b0;
      if (c < NCH && a < DEP) shadow[c][a] = d;
   endtask

   // One pixel in, result sampled two edges later
   task automatic one_pixel(int x0, int x1, int x2, string req);
      @(negedge clk);
      set_pix(x0, x1, x2);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check(req, int'(out_valid), 1);
      check(req, chan_out(0), model(0, x0));
      check(req, chan_out(1), model(1, x1));
      check(req, chan_out(2), model(2, x2));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int s0, s1, s2;
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset and right after release
      check("R1", int'(out_valid), 0);
      check("R1", int'(out_pix == '0), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", int'(out_valid), 0);
      check("R1", int'(out_pix == '0), 1);

      // Load all three tables (R8)
      for (int c = 0; c < NCH; c++)
         for (int i = 0; i < DEP; i++)
            do_write(c, i, init_val(c, i));

      // Vector sweep: ch0 gets x, ch1 gets -x (R2), ch2 gets x
      for (int v = 0; v < NV; v++) begin
         if (VEC[v] >= 3072 || VEC[v] <= -3072)  one_pixel(VEC[v], -VEC[v], VEC[v], "R5");
         else if (VEC[v] >= 1024 || VEC[v] <= -1024) one_pixel(VEC[v], -VEC[v], VEC[v], "R4");
         else one_pixel(VEC[v], -VEC[v], VEC[v], "R3");
      end

      // R2: mirrored pair compared directly
      one_pixel(-1501, 1501, -37, "R2");
      one_pixel(601, -601, -2999, "R2");

      // R8: write with a pixel on the same edge sees the old entry
      s0 = shadow[0][100];
      @(negedge clk);
      wr_en = 1'b1; wr_chan = 2'd0; wr_addr = 10'd100; wr_data = 12'd3333;
      set_pix(200, 0, 0);
      in_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      shadow[0][100] = 3333;
      set_pix(200, 0, 0);
      @(negedge clk);
      in_valid = 1'b0;
      check("R8", int'(out_valid), 1);
      check("R8", chan_out(0), s0);
      @(negedge clk);
      check("R8", int'(out_valid), 1);
      check("R8", chan_out(0), 3333);

      // R10: write to channel 1 leaves channels 0 and 2 as they were
      s0 = model(0, 300); s2 = model(2, 300);
      do_write(1, 150, 77);
      one_pixel(300, 300, 300, "R10");
      check("R10", chan_out(0), s0);
      check("R10", chan_out(2), s2);
      check("R10", chan_out(1), 77);

      // R9: dropped writes (address 514, 1023; channel 3)
      s0 = model(0, 4); s1 = model(1, 4); s2 = model(2, 4);
      do_write(0, 514, 999);
      do_write(1, 1023, 999);
      do_write(3, 2, 999);
      one_pixel(4, 4, 4, "R9");
      check("R9", chan_out(0), s0);
      check("R9", chan_out(1), s1);
      check("R9", chan_out(2), s2);
      s0 = model(0, 1022); s1 = model(1, 1022);
      one_pixel(1022, 1022, 1022, "R9");
      check("R9", chan_out(0), s0);
      check("R9", chan_out(1), s1);
      one_pixel(3500, 1100, 2500, "R9");

      // R6: equal overshoot node saturates channel 0
      do_write(0, 513, shadow[0][512]);
      one_pixel(2000, 2000, 2000, "R6");
      check("R6", chan_out(0), shadow[0][512]);
      one_pixel(-3072, 1024, 4095, "R6");
      check("R6", chan_out(0), shadow[0][512]);
      one_pixel(4095, 3000, 1025, "R6");
      check("R6", chan_out(0), shadow[0][512]);

      // R7: streaming burst, one result per clock two edges behind
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            check("R7", int'(out_valid), (k - 2 < 5) ? 1 : 0);
            if (k - 2 < 5) begin
               check("R7", chan_out(0), model(0, (k - 2) * 611));
               check("R7", chan_out(1), model(1, -(k - 2) * 509));
               check("R7", chan_out(2), model(2, (k - 2) * 37));
            end
         end
         if (k < 5) begin
            set_pix(k * 611, -k * 509, k * 37);
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end

      // R1: reset again mid-run clears the outputs
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", int'(out_valid), 0);
      check("R1", int'(out_pix == '0), 1);
      rst_n = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule